// File: doc/BRIEF.md
# I2C Clock Rate Generator with Two-Stage Divider

This block derives the I2C bit timing from the system clock. A small prescaler divides the clock by A+1. A second counter divides the prescaler's pulses by B+1 and so produces one timing tick every (A+1)·(B+1) clocks. A phase counter splits every SCL period into 22 ticks: 11 with the line held low and 11 with it released. It raises single-cycle strobes for the transfer sequencer when SCL falls, when SCL rises, when SDA should change and when SDA should be sampled. The SCL rate is therefore the clock rate divided by 22·(A+1)·(B+1). Software chooses A and B so that the result stays within the 400 kHz fast-mode limit.

The sequencer raises `run` to start the clock and drops it to stop at a point of its choosing. The divider fields are taken in only while the generator is idle. While SCL is released, the block watches the line. If another device holds it low, counting pauses until the line reads high, so a slow target can stretch the clock.

Top module: `scl_rate_gen`

## Requirements
- R1: While `rst` is high, and on the first sampling after it is released, `scl_pull_low` and all four strobes are 0, whatever `run` does.
- R2: While the generator is idle (one clock after `run` is seen low), `scl_pull_low` is 0 and no strobe is raised.
- R3: On the first clock edge at which `run` is seen high while idle, `scl_fall_stb` pulses and `scl_pull_low` goes to 1. With N = (A+1)·(B+1) and no stretching, the next `scl_fall_stb` comes exactly 22·N clocks later.
- R4: `scl_pull_low` stays 1 for the first 11·N clocks of a period. `scl_rise_stb` pulses at offset 11·N, and from that offset `scl_pull_low` is 0 until the next fall.
- R5: `sda_upd_stb` pulses exactly once per period, at offset 5·N after the fall strobe.
- R6: `sda_smp_stb` pulses exactly once per period, at offset 16·N after the fall strobe. This is the middle of the released half.
- R7: `div_a` (2 bits, value A in 0..3) sets the first-stage division A+1. `div_b` (6 bits, value B in 0..63) sets the second-stage division B+1. Every pair of values yields the period 22·(A+1)·(B+1).
- R8: The divider fields are sampled only while idle. A change to `div_a` or `div_b` while running leaves the current period and the following periods unchanged, and it takes effect after the next idle spell.
- R9: Each clock during which SCL is released but `scl_in` reads low delays the sample strobe and the next fall strobe by one clock. A low `scl_in` during the low half has no effect.
- R10: At most one strobe is high in any cycle, and each strobe lasts one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| run | input | 1 | Sequencer request to run the SCL clock |
| div_a | input | 2 | First-stage divider value A (divide by A+1) |
| div_b | input | 6 | Second-stage divider value B (divide by B+1) |
| scl_in | input | 1 | Sensed SCL line level |
| scl_pull_low | output | 1 | 1 = drive SCL low, 0 = release it |
| scl_fall_stb | output | 1 | Pulse: SCL low half begins |
| scl_rise_stb | output | 1 | Pulse: SCL released, high half begins |
| sda_upd_stb | output | 1 | Pulse: point to change SDA |
| sda_smp_stb | output | 1 | Pulse: point to sample SDA |

## Verification
The divider is swept over every B with A=0, and over every A with B in {0, 1, 7, 63}. This separates a fault in either stage, such as an off-by-one or a stage swapped with the other, from the product law, because every strobe offset is checked against N computed in the bench. A run in which both fields change part-way through tells apart sampling at idle from sampling live: the period must stay at the old N and switch only after a restart. Stretch patterns hold the line low once in the released half and once in the driven half. The first must delay the sample and fall strobes by exactly the hold length, and the second must change nothing.

// File: rtl/scl_rate_pkg.sv
package scl_rate_pkg;

    // Ticks in each half of an SCL period and the positions of the SDA points.
    localparam int unsigned HALF_TICKS   = 11;
    localparam int unsigned PERIOD_TICKS = 2 * HALF_TICKS;
    localparam int unsigned SDA_UPD_TICK = 5;
    localparam int unsigned SDA_SMP_TICK = HALF_TICKS + 5;
    localparam int unsigned PHASE_W      = $clog2(PERIOD_TICKS);

    typedef logic [PHASE_W-1:0] phase_t;

    typedef enum logic {
        SEQ_IDLE   = 1'b0,
        SEQ_ACTIVE = 1'b1
    } seq_state_t;

    typedef struct packed {
        logic fall;
        logic rise;
        logic upd;
        logic smp;
    } scl_strobe_t;

    function automatic phase_t next_phase(input phase_t cur);
        if (cur == phase_t'(PERIOD_TICKS - 1))
            return '0;
        return cur + phase_t'(1);
    endfunction

    function automatic logic in_high_half(input phase_t cur);
        return cur >= phase_t'(HALF_TICKS);
    endfunction

    // Strobes raised when the phase counter lands on a given tick.
    function automatic scl_strobe_t strobes_for(input phase_t landing);
        scl_strobe_t s;
        s.fall = (landing == phase_t'(0));
        s.rise = (landing == phase_t'(HALF_TICKS));
        s.upd  = (landing == phase_t'(SDA_UPD_TICK));
        s.smp  = (landing == phase_t'(SDA_SMP_TICK));
        return s;
    endfunction

endpackage

// File: rtl/scl_div_cfg.sv
module scl_div_cfg #(
    parameter int unsigned A_W = 2,
    parameter int unsigned B_W = 6
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           load,
    input  logic [A_W-1:0] a_in,
    input  logic [B_W-1:0] b_in,
    output logic [A_W-1:0] a_q,
    output logic [B_W-1:0] b_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            a_q <= '0;
            b_q <= '0;
        end else if (load) begin
            a_q <= a_in;
            b_q <= b_in;
        end
    end

    // R8: divider values never move while the generator runs
    a_r8_cfg_frozen: assert property (@(posedge clk) disable iff (rst)
        !load |=> $stable({a_q, b_q}));

endmodule

// File: rtl/scl_pulse_div.sv
module scl_pulse_div #(
    parameter int unsigned W = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clr,
    input  logic         en,
    input  logic [W-1:0] limit,
    output logic         pulse
);

    logic [W-1:0] cnt;

    assign pulse = en && (cnt == limit);

    always_ff @(posedge clk) begin
        if (rst || clr)
            cnt <= '0;
        else if (en)
            cnt <= pulse ? '0 : cnt + W'(1);
    end

    // R7: the count never passes the programmed terminal value
    a_r7_cnt_bound: assert property (@(posedge clk) disable iff (rst)
        cnt <= limit);

    // R9: a paused stage keeps its count
    a_r9_count_paused: assert property (@(posedge clk) disable iff (rst)
        (!en && !clr) |=> $stable(cnt));

endmodule

// File: rtl/scl_phase_seq.sv
module scl_phase_seq
    import scl_rate_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        run,
    input  logic        tick,
    input  logic        scl_sense,
    output logic        active,
    output logic        count_en,
    output logic        scl_pull_low,
    output scl_strobe_t stb
);

    seq_state_t state;
    phase_t     phase;
    logic       released;
    logic       held_by_peer;

    assign active       = (state == SEQ_ACTIVE);
    assign released     = in_high_half(phase);
    assign held_by_peer = released && !scl_sense;
    assign count_en     = active && run && !held_by_peer;
    assign scl_pull_low = active && !released;

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= SEQ_IDLE;
            phase <= '0;
            stb   <= '0;
        end else begin
            stb <= '0;
            case (state)
                SEQ_IDLE: begin
                    if (run) begin
                        state    <= SEQ_ACTIVE;
                        phase    <= '0;
                        stb.fall <= 1'b1;
                    end
                end
                default: begin
                    if (!run) begin
                        state <= SEQ_IDLE;
                        phase <= '0;
                    end else if (tick) begin
                        phase <= next_phase(phase);
                        stb   <= strobes_for(next_phase(phase));
                    end
                end
            endcase
        end
    end

    // R10: strobes are mutually exclusive
    a_r10_strobe_excl: assert property (@(posedge clk) disable iff (rst)
        $onehot0(stb));

    // R3: a fall strobe coincides with the line being driven low
    a_r3_fall_drives_low: assert property (@(posedge clk) disable iff (rst)
        stb.fall |-> scl_pull_low);

    // R4: a rise strobe coincides with the line being released
    a_r4_rise_releases: assert property (@(posedge clk) disable iff (rst)
        stb.rise |-> !scl_pull_low);

    // R2: a dropped request quiets the outputs on the next cycle
    a_r2_idle_quiet: assert property (@(posedge clk) disable iff (rst)
        !run |=> (!scl_pull_low && stb == '0));

    // R9: a peer holding the released line freezes the phase
    a_r9_stretch_freeze: assert property (@(posedge clk) disable iff (rst)
        (active && run && held_by_peer) |=> ($stable(phase) && stb == '0));

endmodule

// File: rtl/scl_rate_gen.sv
module scl_rate_gen
    import scl_rate_pkg::*;
#(
    parameter int unsigned A_W      = 2,
    parameter int unsigned B_W      = 6,
    parameter int unsigned SCL_SYNC = 0
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           run,
    input  logic [A_W-1:0] div_a,
    input  logic [B_W-1:0] div_b,
    input  logic           scl_in,
    output logic           scl_pull_low,
    output logic           scl_fall_stb,
    output logic           scl_rise_stb,
    output logic           sda_upd_stb,
    output logic           sda_smp_stb
);

    logic           scl_sense;
    logic           active;
    logic           count_en;
    logic           pre_pulse;
    logic           tick;
    logic [A_W-1:0] a_q;
    logic [B_W-1:0] b_q;
    scl_strobe_t    stb;

    // Optional resynchronisation of the sensed line.
    generate
        if (SCL_SYNC == 0) begin : g_no_sync
            assign scl_sense = scl_in;
        end else begin : g_sync
            logic [SCL_SYNC-1:0] sync_q;
            always_ff @(posedge clk) begin
                if (rst) begin
                    sync_q <= '1;
                end else begin
                    sync_q[0] <= scl_in;
                    for (int i = 1; i < SCL_SYNC; i++)
                        sync_q[i] <= sync_q[i-1];
                end
            end
            assign scl_sense = sync_q[SCL_SYNC-1];
        end
    endgenerate

    scl_div_cfg #(.A_W(A_W), .B_W(B_W)) u_cfg (
        .clk  (clk),
        .rst  (rst),
        .load (!active),
        .a_in (div_a),
        .b_in (div_b),
        .a_q  (a_q),
        .b_q  (b_q)
    );

    scl_pulse_div #(.W(A_W)) u_stage_a (
        .clk   (clk),
        .rst   (rst),
        .clr   (!active),
        .en    (count_en),
        .limit (a_q),
        .pulse (pre_pulse)
    );

    scl_pulse_div #(.W(B_W)) u_stage_b (
        .clk   (clk),
        .rst   (rst),
        .clr   (!active),
        .en    (pre_pulse),
        .limit (b_q),
        .pulse (tick)
    );

    scl_phase_seq u_seq (
        .clk          (clk),
        .rst          (rst),
        .run          (run),
        .tick         (tick),
        .scl_sense    (scl_sense),
        .active       (active),
        .count_en     (count_en),
        .scl_pull_low (scl_pull_low),
        .stb          (stb)
    );

    assign scl_fall_stb = stb.fall;
    assign scl_rise_stb = stb.rise;
    assign sda_upd_stb  = stb.upd;
    assign sda_smp_stb  = stb.smp;

    // R7: the second stage only advances on a first-stage pulse
    a_r7_tick_needs_pre: assert property (@(posedge clk) disable iff (rst)
        tick |-> pre_pulse);

    // R1: reset forces a released, quiet line
    a_r1_reset_quiet: assert property (@(posedge clk)
        rst |=> (!scl_pull_low && stb == '0));

endmodule

// File: tb/scl_rate_gen_tb_top.sv
`timescale 1ns/1ps
module scl_rate_gen_tb_top;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       run = 1'b0;
    logic [1:0] div_a = '0;
    logic [5:0] div_b = '0;
    logic       hold_low = 1'b0;
    logic       scl_line;
    logic       scl_pull_low, scl_fall_stb, scl_rise_stb, sda_upd_stb, sda_smp_stb;

    int n_tests = 0;
    int n_fail  = 0;
    int cyc     = 0;

    always #10 clk = ~clk;

    // Open-drain line: low if the block drives it or a peer holds it.
    assign scl_line = !scl_pull_low && !hold_low;

    scl_rate_gen dut_i (
        .clk          (clk),
        .rst          (rst),
        .run          (run),
        .div_a        (div_a),
        .div_b        (div_b),
        .scl_in       (scl_line),
        .scl_pull_low (scl_pull_low),
        .scl_fall_stb (scl_fall_stb),
        .scl_rise_stb (scl_rise_stb),
        .sda_upd_stb  (sda_upd_stb),
        .sda_smp_stb  (sda_smp_stb)
    );

    task automatic report();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc == 190000) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual %0d cycles expected < %0d", cyc, 190000);
            report();
            $finish;
        end
    end

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic int strobe_sum();
        return int'(scl_fall_stb) + int'(scl_rise_stb) + int'(sda_upd_stb) + int'(sda_smp_stb);
    endfunction

    task automatic check_quiet(input string req);
        @(negedge clk);
        check(!scl_pull_low && strobe_sum() == 0, req, "idle outputs",
              {scl_pull_low, scl_fall_stb, scl_rise_stb, sda_upd_stb, sda_smp_stb}, 0);
    endtask

    task automatic start_run(input string req);
        run = 1'b1;
        @(negedge clk);
        check(scl_fall_stb && scl_pull_low, req, "start fall/low",
              {scl_fall_stb, scl_pull_low}, 2'b11);
    endtask

    // Called at offset 0 of a period; returns at the next fall strobe.
    task automatic watch_period(input int n, input int lo_from, input int lo_len,
                                input int hi_len, input int chg_t,
                                input logic [1:0] chg_a, input logic [5:0] chg_b,
                                input string req);
        int t_upd = -1, t_rise = -1, t_smp = -1, t_fall = -1;
        int c_upd = 0, c_rise = 0, c_smp = 0, c_fall = 0, multi = 0;
        bit low_ok = 1'b1, high_ok = 1'b1;
        int last = 22 * n + hi_len;
        for (int t = 1; t <= last; t++) begin
            @(negedge clk);
            if (strobe_sum() > 1) multi++;
            if (sda_upd_stb)  begin c_upd++;  if (t_upd  < 0) t_upd  = t; end
            if (scl_rise_stb) begin c_rise++; if (t_rise < 0) t_rise = t; end
            if (sda_smp_stb)  begin c_smp++;  if (t_smp  < 0) t_smp  = t; end
            if (scl_fall_stb) begin c_fall++; if (t_fall < 0) t_fall = t; end
            if (t < 11 * n && !scl_pull_low) low_ok = 1'b0;
            if (t >= 11 * n && t < last && scl_pull_low) high_ok = 1'b0;
            hold_low = ((t >= lo_from) && (t < lo_from + lo_len)) ||
                       ((t >= 11 * n) && (t < 11 * n + hi_len));
            if (t == chg_t) begin
                div_a = chg_a;
                div_b = chg_b;
            end
        end
        hold_low = 1'b0;
        check(t_upd == 5 * n && c_upd == 1, "R5", "sda update offset", t_upd, 5 * n);
        check(t_rise == 11 * n && c_rise == 1, "R4", "rise offset", t_rise, 11 * n);
        check(low_ok && high_ok, "R4", "line level per half", {low_ok, high_ok}, 2'b11);
        check(t_smp == 16 * n + hi_len && c_smp == 1,
              (hi_len > 0) ? "R9" : "R6", "sample offset", t_smp, 16 * n + hi_len);
        check(t_fall == last && c_fall == 1, req, "period", t_fall, last);
        check(multi == 0, "R10", "overlapping strobes", multi, 0);
    endtask

    task automatic stop_run();
        run = 1'b0;
        check_quiet("R2");
        check_quiet("R2");
    endtask

    task automatic sweep_one(input int a, input int b);
        div_a = 2'(a);
        div_b = 6'(b);
        check_quiet("R2");
        start_run("R3");
        watch_period((a + 1) * (b + 1), -1, 0, 0, -1, 2'd0, 6'd0, "R7");
        stop_run();
    endtask

    initial begin
        // R1: reset dominates a raised request
        run = 1'b1;
        repeat (3) begin
            @(negedge clk);
            check(!scl_pull_low && strobe_sum() == 0, "R1", "during reset",
                  {scl_pull_low, scl_fall_stb}, 0);
        end
        run = 1'b0;
        rst = 1'b0;
        @(negedge clk);
        check(!scl_pull_low && strobe_sum() == 0, "R1", "after reset",
              {scl_pull_low, scl_fall_stb}, 0);

        // R7: every B with the first stage bypassed
        for (int b = 0; b < 64; b++) sweep_one(0, b);
        // R7: every A against selected B
        for (int a = 1; a < 4; a++) begin
            sweep_one(a, 0);
            sweep_one(a, 1);
            sweep_one(a, 7);
            sweep_one(a, 63);
        end

        // R8: fields changed mid-run are ignored until the next idle spell
        div_a = 2'd0;
        div_b = 6'd3;
        check_quiet("R2");
        start_run("R3");
        watch_period(4, -1, 0, 0, 20, 2'd3, 6'd63, "R8");
        watch_period(4, -1, 0, 0, -1, 2'd0, 6'd0, "R8");
        stop_run();
        start_run("R8");
        watch_period(256, -1, 0, 0, -1, 2'd0, 6'd0, "R8");
        stop_run();

        // R9: stretching in the released half, none in the driven half
        div_a = 2'd1;
        div_b = 6'd1;
        check_quiet("R2");
        start_run("R3");
        watch_period(4, 2, 6, 0, -1, 2'd0, 6'd0, "R9");
        watch_period(4, -1, 0, 7, -1, 2'd0, 6'd0, "R9");
        watch_period(4, -1, 0, 0, -1, 2'd0, 6'd0, "R3");
        stop_run();

        div_a = 2'd0;
        div_b = 6'd0;
        check_quiet("R2");
        start_run("R3");
        watch_period(1, -1, 0, 3, -1, 2'd0, 6'd0, "R9");
        stop_run();

        report();
        $finish;
    end

endmodule